// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a write-back data cache for one processor load/store port. The main store is a direct-mapped array of lines. A small fully associative buffer sits behind it and holds the lines most recently pushed out of that array. When a request misses the array, the buffer is searched. If the buffer holds the line, the two lines trade places and no memory cycle is spent. If neither holds the line, one whole line is read from a simple memory port. Before that read, a dirty line that must leave the buffer is written back.

On the processor side there is one word per request, a ready signal and a one-cycle response strobe. On the memory side there are whole-line read and write requests with an acknowledge handshake. Only one miss is in progress at a time. Requests that hit the main array can follow each other in every cycle.

Top module: `victim_cache`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cpu_ready` is 1, `cpu_rsp_valid` is 0 and `mem_req` is 0.
- R2: A request whose line is in the main array gets `cpu_rsp_valid` exactly one cycle after the cycle it was accepted (`cpu_req` and `cpu_ready` both high), with no memory request. A response never coincides with an active `mem_req`.
- R3: A request that misses the main array but hits the victim buffer gets its response two cycles after acceptance, with no memory request. The requested line moves into the main array.
- R4: A request that misses both stores causes exactly one line read. The read address is the word address shifted right by log2(WORDS), and the set index is the next log2(SETS) bits. Word w of a line sits at bits [w*DATA_W +: DATA_W]. The response comes in the cycle after the read's `mem_ack`.
- R5: A load returns the last value stored to that word address, or the memory contents if the word was never stored. On a store the response returns the stored word.
- R6: A valid line displaced from the main array, either by a fill or by a swap, enters the victim buffer, so the next access to it is a victim hit. A line is never present twice in the buffer.
- R7: The victim buffer holds VB_N lines. It fills free slots first. When it is full, the entry least recently inserted is dropped, and a later access to that line misses both stores.
- R8: When a dropped entry is dirty, one line write to that entry's line address completes before the fill read starts. A clean drop writes nothing.
- R9: The dirty state and data travel with a line through swaps and evictions, so a stored value survives any number of moves and reaches memory on write-back.
- R10: `cpu_ready` is low from the cycle after a missing request is accepted until its response; it is always low while `mem_req` is high.
- R11: Once raised, `mem_req` holds its address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request strobe |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request is accepted this cycle when high |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rdata | output | DATA_W | Load data (store data on a store) |
| mem_req | output | 1 | Memory line request, held until acknowledged |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W-log2(WORDS) | Line address |
| mem_wdata | output | DATA_W*WORDS | Line written back |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | DATA_W*WORDS | Line read, valid with `mem_ack` |

## Verification
Two events can land on the same clock edge. In the completion cycle of a swap, the buffer slot that gives up the requested line receives the displaced line in that same edge. In a fill, the dirty line evicted from the main array enters the buffer in the same edge that the oldest buffer entry is overwritten after its write-back. The bench provokes both by cycling five and six distinct lines through one set, then runs long pseudo-random mixes of loads and stores over eight lines per set at several memory delays. It judges the outcome three ways. A reference model keeps the buffer as an ordered list and predicts the exact response latency and the address of every write-back. The written-back line data must equal a flat model of memory. Every load must return that flat model's value.

// File: rtl/vc_pkg.sv
package vc_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_VB   = 2'd1,
      ST_WB   = 2'd2,
      ST_FILL = 2'd3
   } vc_state_e;
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
   parameter int SETS   = 4,
   parameter int TAG_W  = 5,
   parameter int LINE_W = 32,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_dirty,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_line
);
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [LINE_W-1:0] line_q [SETS];
   logic [SETS-1:0]   valid_q;
   logic [SETS-1:0]   dirty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         dirty_q[wr_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         line_q[wr_idx] <= wr_line;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_line  = line_q[rd_idx];
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
   parameter int N = 4,
   localparam int SW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [SW-1:0] touch_slot,
   output logic [SW-1:0] lru_slot
);
   // age 0 = most recent, N-1 = least recent; ages always form a permutation
   logic [SW-1:0] age_q [N];
   logic [SW-1:0] touch_age;

   assign touch_age = age_q[touch_slot];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age_q[i] <= SW'(i);
      end else if (touch) begin
         for (int i = 0; i < N; i++) begin
            if (touch_slot == SW'(i))      age_q[i] <= '0;
            else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      lru_slot = '0;
      for (int i = 0; i < N; i++)
         if (age_q[i] == SW'(N - 1)) lru_slot = SW'(i);
   end
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
   parameter int N      = 4,
   parameter int LA_W   = 7,
   parameter int LINE_W = 32,
   localparam int SW    = $clog2(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LA_W-1:0]   lk_addr,
   output logic [N-1:0]      lk_match,
   input  logic [SW-1:0]     hit_slot,
   output logic [LINE_W-1:0] hit_line,
   output logic              hit_dirty,
   output logic [SW-1:0]     vic_slot,
   output logic              vic_valid,
   output logic              vic_dirty,
   output logic [LA_W-1:0]   vic_addr,
   output logic [LINE_W-1:0] vic_line,
   input  logic              wr_en,
   input  logic [SW-1:0]     wr_slot,
   input  logic              wr_valid,
   input  logic              wr_dirty,
   input  logic [LA_W-1:0]   wr_addr,
   input  logic [LINE_W-1:0] wr_line
);
   logic [LA_W-1:0]   addr_q [N];
   logic [LINE_W-1:0] line_q [N];
   logic [N-1:0]      valid_q;
   logic [N-1:0]      dirty_q;
   logic              free_any;
   logic [SW-1:0]     free_slot;
   logic [SW-1:0]     lru_slot;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign lk_match[i] = valid_q[i] && (addr_q[i] == lk_addr);
   end

   // lowest-numbered empty slot wins; LRU only when all are full
   always_comb begin
      free_any  = 1'b0;
      free_slot = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_q[i]) begin
            free_any  = 1'b1;
            free_slot = SW'(i);
         end
      end
   end

   vc_lru #(.N(N)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch      (wr_en && wr_valid),
      .touch_slot (wr_slot),
      .lru_slot   (lru_slot)
   );

   assign vic_slot  = free_any ? free_slot : lru_slot;
   assign vic_valid = valid_q[vic_slot];
   assign vic_dirty = dirty_q[vic_slot];
   assign vic_addr  = addr_q[vic_slot];
   assign vic_line  = line_q[vic_slot];
   assign hit_line  = line_q[hit_slot];
   assign hit_dirty = dirty_q[hit_slot];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_slot] <= wr_valid;
         dirty_q[wr_slot] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         addr_q[wr_slot] <= wr_addr;
         line_q[wr_slot] <= wr_line;
      end
   end
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int WORDS  = 2,
   parameter int SETS   = 4,
   parameter int VB_N   = 4,
   localparam int OFF_W  = $clog2(WORDS),
   localparam int LA_W   = ADDR_W - OFF_W,
   localparam int LINE_W = DATA_W * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_rsp_valid,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [LA_W-1:0]   mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [LINE_W-1:0] mem_rdata
);
   import vc_pkg::*;

   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = LA_W - IDX_W;
   localparam int SLOT_W = $clog2(VB_N);

   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two, at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (VB_N < 2 || (VB_N & (VB_N - 1)) != 0) begin : g_bad_vb
      $error("VB_N must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W leaves no tag bits");
   end

   vc_state_e st_q, st_d;
   logic              req_we_q;
   logic [ADDR_W-1:0] req_addr_q;
   logic [DATA_W-1:0] req_wdata_q;
   logic              rsp_v_q;
   logic [DATA_W-1:0] rdata_q;

   logic              cur_we;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata;
   logic [IDX_W-1:0]  cur_idx;
   logic [TAG_W-1:0]  cur_tag;
   logic [OFF_W-1:0]  cur_off;
   logic [LA_W-1:0]   cur_la;

   logic              m_valid, m_dirty, m_hit;
   logic [TAG_W-1:0]  m_tag;
   logic [LINE_W-1:0] m_line;

   logic [VB_N-1:0]   vb_match;
   logic              vb_hit, vb_swap;
   logic [SLOT_W-1:0] vb_slot;
   logic [LINE_W-1:0] hit_line;
   logic              hit_dirty;
   logic [SLOT_W-1:0] vic_slot;
   logic              vic_valid, vic_dirty;
   logic [LA_W-1:0]   vic_addr;
   logic [LINE_W-1:0] vic_line;

   logic              accept, fill_done, done;
   logic              main_wr, main_wr_dirty;
   logic              vb_wr, vb_wr_valid;
   logic [SLOT_W-1:0] vb_wr_slot;
   logic [LINE_W-1:0] src_line, merged;
   logic [DATA_W-1:0] rword;

   // ---------------- request selection ----------------
   assign cur_we    = (st_q == ST_RUN) ? cpu_we    : req_we_q;
   assign cur_addr  = (st_q == ST_RUN) ? cpu_addr  : req_addr_q;
   assign cur_wdata = (st_q == ST_RUN) ? cpu_wdata : req_wdata_q;
   assign cur_off   = cur_addr[OFF_W-1:0];
   assign cur_idx   = cur_addr[OFF_W +: IDX_W];
   assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
   assign cur_la    = cur_addr[ADDR_W-1:OFF_W];

   // ---------------- storage ----------------
   vc_main_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (cur_idx),
      .rd_valid (m_valid),
      .rd_dirty (m_dirty),
      .rd_tag   (m_tag),
      .rd_line  (m_line),
      .wr_en    (main_wr),
      .wr_idx   (cur_idx),
      .wr_dirty (main_wr_dirty),
      .wr_tag   (cur_tag),
      .wr_line  (merged)
   );

   vc_victim_buf #(.N(VB_N), .LA_W(LA_W), .LINE_W(LINE_W)) u_vb (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_addr   (cur_la),
      .lk_match  (vb_match),
      .hit_slot  (vb_slot),
      .hit_line  (hit_line),
      .hit_dirty (hit_dirty),
      .vic_slot  (vic_slot),
      .vic_valid (vic_valid),
      .vic_dirty (vic_dirty),
      .vic_addr  (vic_addr),
      .vic_line  (vic_line),
      .wr_en     (vb_wr),
      .wr_slot   (vb_wr_slot),
      .wr_valid  (vb_wr_valid),
      .wr_dirty  (m_dirty),
      .wr_addr   ({m_tag, cur_idx}),
      .wr_line   (m_line)
   );

   always_comb begin
      vb_slot = '0;
      for (int i = 0; i < VB_N; i++)
         if (vb_match[i]) vb_slot = SLOT_W'(i);
   end

   assign m_hit     = m_valid && (m_tag == cur_tag);
   assign vb_hit    = |vb_match;
   assign accept    = (st_q == ST_RUN) && cpu_req;
   assign vb_swap   = (st_q == ST_VB) && vb_hit;
   assign fill_done = (st_q == ST_FILL) && mem_ack;
   assign done      = (accept && m_hit) || vb_swap || fill_done;

   // ---------------- line data path ----------------
   always_comb begin
      unique case (st_q)
         ST_VB:   src_line = hit_line;
         ST_FILL: src_line = mem_rdata;
         default: src_line = m_line;
      endcase
   end

   always_comb begin
      merged = src_line;
      for (int w = 0; w < WORDS; w++)
         if (cur_we && cur_off == OFF_W'(w)) merged[w*DATA_W +: DATA_W] = cur_wdata;
   end

   assign rword = merged[cur_off*DATA_W +: DATA_W];

   // ---------------- array updates ----------------
   assign main_wr = (accept && m_hit && cur_we) || vb_swap || fill_done;

   always_comb begin
      unique case (st_q)
         ST_VB:   main_wr_dirty = hit_dirty | cur_we;
         ST_FILL: main_wr_dirty = cur_we;
         default: main_wr_dirty = 1'b1;
      endcase
   end

   // swap: the displaced line takes the freed slot; fill: it takes the victim slot
   assign vb_wr       = vb_swap || (fill_done && m_valid);
   assign vb_wr_slot  = vb_swap ? vb_slot : vic_slot;
   assign vb_wr_valid = m_valid;

   // ---------------- control ----------------
   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN:  if (accept && !m_hit) st_d = ST_VB;
         ST_VB: begin
            if (vb_hit)                                 st_d = ST_RUN;
            else if (m_valid && vic_valid && vic_dirty) st_d = ST_WB;
            else                                        st_d = ST_FILL;
         end
         ST_WB:   if (mem_ack) st_d = ST_FILL;
         ST_FILL: if (mem_ack) st_d = ST_RUN;
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_RUN;
         rsp_v_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         rsp_v_q <= done;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         req_we_q    <= cpu_we;
         req_addr_q  <= cpu_addr;
         req_wdata_q <= cpu_wdata;
      end
      if (done) rdata_q <= rword;
   end

   assign cpu_ready     = (st_q == ST_RUN);
   assign cpu_rsp_valid = rsp_v_q;
   assign cpu_rdata     = rdata_q;
   assign mem_req       = (st_q == ST_WB) || (st_q == ST_FILL);
   assign mem_we        = (st_q == ST_WB);
   assign mem_addr      = (st_q == ST_WB) ? vic_addr : cur_la;
   assign mem_wdata     = vic_line;
endmodule

// File: rtl/vc_chk.sv
module vc_chk #(
   parameter int LA_W = 7,
   parameter int VB_N = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cpu_ready,
   input logic            cpu_rsp_valid,
   input logic            mem_req,
   input logic            mem_we,
   input logic [LA_W-1:0] mem_addr,
   input logic            mem_ack,
   input logic            vb_swap,
   input logic [VB_N-1:0] vb_match
);
   // R11
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R10
   busy_during_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready);

   // R4
   fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && !mem_we |=> cpu_rsp_valid);

   // R3
   swap_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vb_swap |=> cpu_rsp_valid && !mem_req);

   // R6
   vb_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vb_match));

   // R8
   wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

   // R2
   rsp_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid |-> !mem_req);
endmodule

bind victim_cache vc_chk #(.LA_W(LA_W), .VB_N(VB_N)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_ready     (cpu_ready),
   .cpu_rsp_valid (cpu_rsp_valid),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_addr      (mem_addr),
   .mem_ack       (mem_ack),
   .vb_swap       (vb_swap),
   .vb_match      (vb_match)
);

// File: tb/sim_victim_cache.sv
module sim_victim_cache;
   localparam int AW = 8, DW = 16, WPL = 2, SETS = 4, VBN = 4, LAW = 7, LW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready, cpu_rsp_valid;
   logic [DW-1:0] cpu_rdata;
   logic          mem_req, mem_we;
   logic [LAW-1:0] mem_addr;
   logic [LW-1:0] mem_wdata;
   logic          mem_ack = 1'b0;
   logic [LW-1:0] mem_rdata = '0;

   victim_cache u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int total = 0, bad = 0;
   logic [DW-1:0] ref_mem [256];
   logic [DW-1:0] bmem [256];
   int mem_delay = 0, wait_cnt = 0, rd_cnt = 0, wr_cnt = 0, last_rd_la = -1, exp_wb_la = -1;

   // reference state: main array per set, victim buffer as an MRU-first list
   bit m_valid [SETS];
   int m_la    [SETS];
   bit m_dirty [SETS];
   int l_la    [VBN];
   bit l_dirty [VBN];
   int l_n = 0;

   function automatic logic [DW-1:0] seed_word(int a);
      return DW'((a * 677) ^ 16'hA5C3);
   endfunction

   task automatic chk(bit ok, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", what, act, exp);
      end
   endtask

   task automatic list_push(int la, bit d);
      for (int k = VBN - 1; k > 0; k--) begin
         l_la[k] = l_la[k-1];
         l_dirty[k] = l_dirty[k-1];
      end
      l_la[0] = la;
      l_dirty[0] = d;
      if (l_n < VBN) l_n++;
   endtask

   // memory model
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         wait_cnt = 0;
      end else if (rst_n && mem_req) begin
         if (wait_cnt >= mem_delay) begin
            mem_ack = 1'b1;
            if (mem_we) begin
               wr_cnt++;
               chk(int'(mem_addr) == exp_wb_la, "R8 write-back line address", int'(mem_addr), exp_wb_la);
               for (int w = 0; w < WPL; w++) begin
                  bmem[int'(mem_addr)*WPL + w] = mem_wdata[w*DW +: DW];
                  chk(mem_wdata[w*DW +: DW] == ref_mem[int'(mem_addr)*WPL + w], "R9 write-back data",
                      int'(mem_wdata[w*DW +: DW]), int'(ref_mem[int'(mem_addr)*WPL + w]));
               end
            end else begin
               rd_cnt++;
               last_rd_la = int'(mem_addr);
               for (int w = 0; w < WPL; w++) mem_rdata[w*DW +: DW] = bmem[int'(mem_addr)*WPL + w];
            end
         end else begin
            wait_cnt++;
         end
      end
   end

   task automatic access(bit we, int a, logic [DW-1:0] wd);
      int la = a / WPL;
      int idx = la % SETS;
      int cls = 2;
      int pos = -1;
      int lat, exp_lat;
      bit wb = 1'b0;
      bit ready_bad = 1'b0;
      logic [DW-1:0] exp_d = we ? wd : ref_mem[a];

      exp_wb_la = -1;
      if (m_valid[idx] && m_la[idx] == la) begin
         cls = 0;
         if (we) m_dirty[idx] = 1'b1;
      end else begin
         for (int k = 0; k < l_n; k++) if (l_la[k] == la) pos = k;
         if (pos >= 0) begin
            bit d = l_dirty[pos];
            cls = 1;
            for (int k = pos; k < VBN - 1; k++) begin
               l_la[k] = l_la[k+1];
               l_dirty[k] = l_dirty[k+1];
            end
            l_n--;
            if (m_valid[idx]) list_push(m_la[idx], m_dirty[idx]);
            m_dirty[idx] = d | we;
         end else begin
            if (m_valid[idx]) begin
               if (l_n == VBN && l_dirty[VBN-1]) begin
                  wb = 1'b1;
                  exp_wb_la = l_la[VBN-1];
               end
               list_push(m_la[idx], m_dirty[idx]);
            end
            m_dirty[idx] = we;
         end
         m_la[idx] = la;
         m_valid[idx] = 1'b1;
      end

      rd_cnt = 0;
      wr_cnt = 0;
      cpu_req = 1'b1;
      cpu_we = we;
      cpu_addr = AW'(a);
      cpu_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0;
      lat = 1;
      while (!cpu_rsp_valid && lat < 80) begin
         if (cpu_ready) ready_bad = 1'b1;
         @(negedge clk);
         lat++;
      end

      exp_lat = (cls == 0) ? 1 : (cls == 1) ? 2 : (wb ? 5 + 2 * mem_delay : 3 + mem_delay);
      case (cls)
         0: begin
            chk(lat == 1, "R2 main-hit latency", lat, 1);
            chk(rd_cnt + wr_cnt == 0, "R2 main-hit memory traffic", rd_cnt + wr_cnt, 0);
         end
         1: begin
            chk(lat == 2, "R3 R6 victim-hit latency", lat, 2);
            chk(rd_cnt + wr_cnt == 0, "R3 victim-hit memory traffic", rd_cnt + wr_cnt, 0);
         end
         default: begin
            chk(lat == exp_lat, "R4 R7 miss latency", lat, exp_lat);
            chk(rd_cnt == 1, "R4 line read count", rd_cnt, 1);
            chk(last_rd_la == la, "R4 fill line address", last_rd_la, la);
            chk(wr_cnt == int'(wb), "R8 write-back count", wr_cnt, int'(wb));
            chk(!ready_bad, "R10 ready low during miss", int'(ready_bad), 0);
         end
      endcase
      chk(cpu_rdata == exp_d, "R5 R9 response data", int'(cpu_rdata), int'(exp_d));
      if (we) ref_mem[a] = wd;
   endtask

   initial begin
      #(200000 * 10);
      chk(1'b0, "watchdog expired R4", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] lf = 16'hACE1;
      for (int a = 0; a < 256; a++) begin
         ref_mem[a] = seed_word(a);
         bmem[a] = seed_word(a);
      end
      for (int s = 0; s < SETS; s++) begin
         m_valid[s] = 1'b0;
         m_dirty[s] = 1'b0;
         m_la[s] = 0;
      end

      repeat (3) @(negedge clk);
      chk(cpu_ready == 1'b1, "R1 ready in reset", int'(cpu_ready), 1);
      chk(cpu_rsp_valid == 1'b0, "R1 no response in reset", int'(cpu_rsp_valid), 0);
      chk(mem_req == 1'b0, "R1 no memory request in reset", int'(mem_req), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_rsp_valid == 1'b0 && mem_req == 1'b0 && cpu_ready == 1'b1,
          "R1 idle after reset", int'({cpu_ready, cpu_rsp_valid, mem_req}), 4);

      // directed: cold miss, hit, store hit
      access(1'b0, 0, '0);
      access(1'b0, 1, '0);
      access(1'b1, 0, 16'hBEEF);
      access(1'b0, 0, '0);

      // six lines in set 0: forces LRU drops and dirty write-backs (R7 R8)
      for (int rep = 0; rep < 3; rep++)
         for (int j = 0; j < 6; j++)
            access(j[0], j * 4 * WPL + (rep & 1), 16'(j * 256 + rep));

      // five lines in set 1: fits main + buffer, steady swaps (R3 R6)
      for (int rep = 0; rep < 4; rep++)
         for (int j = 0; j < 5; j++)
            access(rep[0], (j * 4 + 1) * WPL + 1, 16'(16'h7000 + j * 16 + rep));

      // pseudo-random mixes at several memory delays
      for (int d = 0; d < 4; d++) begin
         mem_delay = d;
         for (int n = 0; n < 300; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            access(lf[7], int'(lf[5:0]), lf ^ 16'(n));
         end
      end

      // exhaustive read-back of the exercised range (R5 R9)
      mem_delay = 1;
      for (int a = 0; a < 64; a++) access(1'b0, a, '0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule